// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Two-Level Operation Decode

This block is the execute-stage arithmetic unit of a simple integer datapath, together with the small decoder that selects its operation. The main control supplies a 2-bit operation class. Only the register-to-register class looks at the 6-bit function field of the instruction. The other classes force an addition (address generation for loads and stores) or a subtraction (equality test for conditional branches).

The unit is purely combinational. It takes two operands of `WIDTH` bits and returns a result, a zero flag and a signed-overflow flag. Branch logic downstream uses the zero flag to decide whether an equal-compare branch is taken. Exception logic downstream uses the overflow flag. The decoded 4-bit select is also brought out, so that neighbouring logic can see which operation ran.

Top module: `alu_unit`

## Requirements
- R1: Operation class 00 produces select 0010 (add), whatever the function field holds.
- R2: Operation class 01 produces select 0110 (subtract), whatever the function field holds.
- R3: Operation class 10 maps the function field as follows: 100100 to select 0000 (AND), 100101 to 0001 (OR), 100000 to 0010 (add), 100010 to 0110 (subtract), 101010 to 0111 (set-on-less-than).
- R4: Under operation class 10, any function code not listed in R3 produces select 0010 (add).
- R5: Operation class 11 is reserved and produces select 0010 (add) for every function code.
- R6: For AND and OR, the result is the bitwise AND or OR of the two operands.
- R7: For add and subtract, the result is a+b or a-b modulo 2^WIDTH.
- R8: For set-on-less-than, bit 0 of the result is 1 exactly when a < b as signed two's-complement values, and all other bits are 0. The comparison stays correct when a-b overflows.
- R9: The zero flag is 1 exactly when every bit of the result is 0.
- R10: For add and subtract, the overflow flag is 1 exactly when the signed result does not fit in WIDTH bits. For AND, OR and set-on-less-than it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Operation class from the main control |
| funct | input | 6 | Function field of the instruction |
| src_a | input | WIDTH | First operand |
| src_b | input | WIDTH | Second operand |
| alu_sel | output | 4 | Decoded operation select |
| result | output | WIDTH | Operation result |
| zero | output | 1 | Result-is-all-zeros flag |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The checker's immediate assertions assume that every input is a settled 0/1 value whenever they are evaluated. They make no assumption about which combinations of class and function code occur. The bench changes inputs only on the falling clock edge and samples one time unit later, so every check sees a settled, fully driven input vector. The stimulus covers all class and function pairs, and every operand pair of a 4-bit instance for each operation. This includes the most-negative and most-positive values, where overflow and the corrected signed compare matter.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [3:0] {
        SEL_AND = 4'b0000,
        SEL_OR  = 4'b0001,
        SEL_ADD = 4'b0010,
        SEL_SUB = 4'b0110,
        SEL_SLT = 4'b0111
    } alu_sel_e;

    typedef enum logic [1:0] {
        CLS_MEM = 2'b00,
        CLS_BEQ = 2'b01,
        CLS_REG = 2'b10,
        CLS_RSV = 2'b11
    } op_class_e;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
(
    input  logic [1:0] cls_i,
    input  logic [5:0] funct_i,
    output alu_sel_e   sel_o
);
    alu_sel_e fn_sel_d;

    // second level: only consulted for the register class
    always_comb begin
        unique case (funct_i)
            FN_AND:  fn_sel_d = SEL_AND;
            FN_OR:   fn_sel_d = SEL_OR;
            FN_SUB:  fn_sel_d = SEL_SUB;
            FN_SLT:  fn_sel_d = SEL_SLT;
            default: fn_sel_d = SEL_ADD;
        endcase
    end

    // first level: class forces add/subtract or defers to function field
    always_comb begin
        unique case (op_class_e'(cls_i))
            CLS_BEQ: sel_o = SEL_SUB;
            CLS_REG: sel_o = fn_sel_d;
            default: sel_o = SEL_ADD;
        endcase
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             ovf_o,
    output logic             lt_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff_d;
    logic [WIDTH:0]   wide_d;

    always_comb begin
        b_eff_d = sub_i ? ~b_i : b_i;
        wide_d  = {1'b0, a_i} + {1'b0, b_eff_d} + {{WIDTH{1'b0}}, sub_i};
        sum_o   = wide_d[WIDTH-1:0];
        ovf_o   = (a_i[MSB] == b_eff_d[MSB]) && (sum_o[MSB] != a_i[MSB]);
        // sign of the true difference: flip the sign bit when it overflowed
        lt_o    = sum_o[MSB] ^ ovf_o;
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign and_o[i] = a_i[i] & b_i[i];
        assign or_o[i]  = a_i[i] | b_i[i];
    end
endmodule

// File: rtl/alu_unit.sv
module alu_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       op_class,
    input  logic [5:0]       funct,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    output logic [3:0]       alu_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             ovf
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             zf;
        logic             of;
    } alu_out_t;

    alu_sel_e         sel_d;
    logic             sub_d;
    logic [WIDTH-1:0] sum_d;
    logic             as_ovf_d;
    logic             lt_d;
    logic [WIDTH-1:0] and_d;
    logic [WIDTH-1:0] or_d;
    alu_out_t         outs_d;

    alu_op_decode dec_i (
        .cls_i   (op_class),
        .funct_i (funct),
        .sel_o   (sel_d)
    );

    assign sub_d = (sel_d == SEL_SUB) || (sel_d == SEL_SLT);

    alu_addsub #(.WIDTH(WIDTH)) addsub_i (
        .a_i   (src_a),
        .b_i   (src_b),
        .sub_i (sub_d),
        .sum_o (sum_d),
        .ovf_o (as_ovf_d),
        .lt_o  (lt_d)
    );

    alu_bitwise #(.WIDTH(WIDTH)) bitwise_i (
        .a_i   (src_a),
        .b_i   (src_b),
        .and_o (and_d),
        .or_o  (or_d)
    );

    always_comb begin
        outs_d = '0;
        unique case (sel_d)
            SEL_AND: outs_d.res = and_d;
            SEL_OR:  outs_d.res = or_d;
            SEL_SLT: outs_d.res = {{(WIDTH-1){1'b0}}, lt_d};
            default: begin
                outs_d.res = sum_d;
                outs_d.of  = as_ovf_d;
            end
        endcase
        outs_d.zf = ~|outs_d.res;
    end

    assign alu_sel = sel_d;
    assign result  = outs_d.res;
    assign zero    = outs_d.zf;
    assign ovf     = outs_d.of;
endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic [1:0]       op_class,
    input logic [5:0]       funct,
    input logic [WIDTH-1:0] src_a,
    input logic [WIDTH-1:0] src_b,
    input logic [3:0]       alu_sel,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             ovf
);
    always_comb begin
        // R1
        mem_class_chk: assert (op_class != 2'b00 || alu_sel == 4'b0010);
        // R2
        beq_class_chk: assert (op_class != 2'b01 || alu_sel == 4'b0110);
        // R5
        rsv_class_chk: assert (op_class != 2'b11 || alu_sel == 4'b0010);
        // R9
        zero_flag_chk: assert (zero == (result == '0));
        // R10
        no_overflow_chk: assert (!ovf || alu_sel == 4'b0010 || alu_sel == 4'b0110);
        // R8
        slt_upper_chk: assert (alu_sel != 4'b0111 || result[WIDTH-1:1] == '0);
        // R6
        and_res_chk: assert (alu_sel != 4'b0000 || result == (src_a & src_b));
    end
endmodule

bind alu_unit alu_unit_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/alu_unit_tb_top.sv
module alu_unit_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [1:0]  op_class;
    logic [5:0]  funct;
    logic [3:0]  a4, b4, sel4, res4;
    logic        z4, v4;
    logic [31:0] a32, b32, res32;
    logic [3:0]  sel32;
    logic        z32, v32;

    alu_unit #(.WIDTH(4)) small_i (
        .op_class(op_class), .funct(funct), .src_a(a4), .src_b(b4),
        .alu_sel(sel4), .result(res4), .zero(z4), .ovf(v4)
    );

    alu_unit #(.WIDTH(32)) dut_i (
        .op_class(op_class), .funct(funct), .src_a(a32), .src_b(b32),
        .alu_sel(sel32), .result(res32), .zero(z32), .ovf(v32)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_sel(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'b01) return 4'b0110;
        if (c != 2'b10) return 4'b0010;
        case (f)
            6'h24:   return 4'b0000;
            6'h25:   return 4'b0001;
            6'h22:   return 4'b0110;
            6'h2A:   return 4'b0111;
            default: return 4'b0010;
        endcase
    endfunction

    // op: 0 and, 1 or, 2 add, 3 sub, 4 slt
    task automatic model(input int w, input longint a, input longint b, input int op,
                         output longint r, output bit v);
        longint mask = (longint'(1) << w) - 1;
        longint half = longint'(1) << (w - 1);
        longint sa = (a >= half) ? a - 2 * half : a;
        longint sb = (b >= half) ? b - 2 * half : b;
        longint s;
        v = 1'b0;
        case (op)
            0: r = a & b;
            1: r = a | b;
            2: begin s = sa + sb; r = s & mask; v = (s >= half) || (s < -half); end
            3: begin s = sa - sb; r = s & mask; v = (s >= half) || (s < -half); end
            default: r = (sa < sb) ? 1 : 0;
        endcase
    endtask

    function automatic logic [5:0] fn_of(input int op);
        case (op)
            0: return 6'h24;
            1: return 6'h25;
            2: return 6'h20;
            3: return 6'h22;
            default: return 6'h2A;
        endcase
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0, 1: return "R6";
            2, 3: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic run32(input logic [1:0] c, input logic [5:0] f, input int op,
                         input longint a, input longint b);
        longint r;
        bit v;
        @(negedge clk);
        op_class = c; funct = f; a32 = a[31:0]; b32 = b[31:0];
        #1;
        model(32, a, b, op, r, v);
        chk(tag_of(op), longint'(res32), r);
        chk("R9", longint'(z32), longint'(r == 0));
        chk("R10", longint'(v32), longint'(v));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        op_class = 2'b00; funct = 6'h00; a4 = '0; b4 = '0; a32 = '0; b32 = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // quiet state with all-zero inputs: add of zeros
        chk("R1", longint'(sel32), 4'b0010);
        chk("R9", longint'(z32), 1);
        chk("R10", longint'(v32), 0);

        // decode sweep over every class and function code
        for (int c = 0; c < 4; c++) begin
            for (int f = 0; f < 64; f++) begin
                string t;
                @(negedge clk);
                op_class = c[1:0]; funct = f[5:0];
                #1;
                t = (c == 0) ? "R1" : (c == 1) ? "R2" : (c == 3) ? "R5" :
                    (exp_sel(2'b10, f[5:0]) == 4'b0010 && f != 6'h20) ? "R4" : "R3";
                chk(t, longint'(sel32), longint'(exp_sel(c[1:0], f[5:0])));
                chk(t, longint'(sel4), longint'(exp_sel(c[1:0], f[5:0])));
            end
        end

        // exhaustive 4-bit sweep for every register-class operation
        for (int op = 0; op < 5; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    longint r;
                    bit v;
                    @(negedge clk);
                    op_class = 2'b10; funct = fn_of(op); a4 = a[3:0]; b4 = b[3:0];
                    #1;
                    model(4, a, b, op, r, v);
                    chk(tag_of(op), longint'(res4), r);
                    chk("R9", longint'(z4), longint'(r == 0));
                    chk("R10", longint'(v4), longint'(v));
                end
            end
        end

        // 32-bit corners, including forced classes
        run32(2'b00, 6'h2A, 2, 64'h7FFF_FFFF, 64'h1);
        run32(2'b00, 6'h24, 2, 64'hFFFF_FFFF, 64'h1);
        run32(2'b01, 6'h25, 3, 64'h5A, 64'h55);
        run32(2'b01, 6'h00, 3, 64'h1234_5678, 64'h1234_5678);
        run32(2'b01, 6'h00, 3, 64'h8000_0000, 64'h1);
        run32(2'b10, 6'h22, 3, 64'h0, 64'h8000_0000);
        run32(2'b10, 6'h2A, 4, 64'h8000_0000, 64'h7FFF_FFFF);
        run32(2'b10, 6'h2A, 4, 64'h7FFF_FFFF, 64'h8000_0000);
        run32(2'b10, 6'h2A, 4, 64'hFFFF_FFFE, 64'hFFFF_FFFF);
        run32(2'b10, 6'h2A, 4, 64'h5, 64'h5);
        run32(2'b10, 6'h24, 0, 64'hF0F0_1234, 64'h0F0F_FFFF);
        run32(2'b10, 6'h25, 1, 64'hF0F0_0000, 64'h0F0F_0001);
        run32(2'b10, 6'h20, 2, 64'h8000_0000, 64'h8000_0000);
        run32(2'b11, 6'h22, 2, 64'hDEAD_BEEF, 64'h2152_4111);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule